// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block divides the system clock into two streams of tick enables. The first stream is the base tick of an infrared serial path, which normally runs near 1.8432 MHz. The second stream is the 16x oversampling tick of a UART. Each tick period is an integer number of clocks plus a correction in sixteenths of a clock. The correction is realised by stretching selected periods by one clock. Over any run of sixteen periods the average period is therefore exact.

Software programs four registers through a simple write port. Each channel has an integer count register and a fraction register that holds a 4-bit correction index. Writing a channel's count register restarts that channel cleanly. A zero in the infrared count field is illegal and is refused. Both outputs are one-cycle enables for logic that runs on the system clock. Neither output is a derived clock.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, both tick outputs are low. After reset, the infrared count field holds 1, which gives a 2-clock period. The UART count field holds 0, and both fraction indices are 0.
- R2: Register select `wr_addr` takes four values: 0 is the infrared fraction, 1 is the infrared count, 2 is the UART fraction and 3 is the UART count. A fraction index is taken from `wr_data[7:4]`. All other bits of a fraction write are ignored.
- R3: The infrared integer period is (count field + 1) clocks. The count field is `wr_data[3:0]`.
- R4: A write of 0 to the infrared count field is refused. The field keeps its value, no restart occurs, and the tick cadence continues unchanged.
- R5: The UART integer period is (count field + 1) × 16 clocks. The count field is `wr_data[11:0]`.
- R6: Every period lasts either the integer period N or N+1 clocks. Periods are numbered j = 0, 1, 2, ... from a restart. Period j is stretched exactly when floor((j+1)·k/16) > floor(j·k/16), where k is the fraction index. Any 16 consecutive periods therefore total 16·N + k clocks.
- R7: A write to a count register restarts that channel as follows:
  - The write is accepted on clock edge E.
  - No tick occurs until the cycle that follows edge E+N.
  - The tick is high in that cycle, which ends period 0.
  - A fraction write alone does not restart the channel.
- R8: Each tick is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| ir_tick | output | 1 | One-cycle infrared base tick |
| uart_tick | output | 1 | One-cycle UART 16x oversampling tick |

## Verification
The bench builds the block with its default parameters: a 4-bit infrared count field, a 12-bit UART count field, a reset infrared count of 1 and two reset-synchroniser stages. Small UART counts keep each UART period between 16 and 48 clocks. Sixteen-period windows can then be measured many times within the run. The infrared field's full range, from divisor 2 to divisor 16, is reachable, so both the fastest legal period and the widest stretch pattern (index 15) are checked.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int DATA_W   = 16;
  localparam int FRAC_W   = 4;
  localparam int FRAC_LSB = 4;

  typedef enum logic [1:0] {
    REG_IR_FRAC = 2'd0,
    REG_IR_CNT  = 2'd1,
    REG_UA_FRAC = 2'd2,
    REG_UA_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int IR_CNT_W   = 4,
  parameter int UA_CNT_W   = 12,
  parameter int IR_CNT_RST = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [FRAC_W-1:0]   ir_frac,
  output logic [IR_CNT_W-1:0] ir_cnt,
  output logic                ir_restart,
  output logic [FRAC_W-1:0]   ua_frac,
  output logic [UA_CNT_W-1:0] ua_cnt,
  output logic                ua_restart
);
  logic [FRAC_W-1:0]   ir_frac_q, ir_frac_n, ua_frac_q, ua_frac_n;
  logic [IR_CNT_W-1:0] ir_cnt_q, ir_cnt_n;
  logic [UA_CNT_W-1:0] ua_cnt_q, ua_cnt_n;
  logic                ir_rs_q, ir_rs_n, ua_rs_q, ua_rs_n;
  logic [FRAC_W-1:0]   frac_field;
  logic [IR_CNT_W-1:0] ir_field;
  logic [UA_CNT_W-1:0] ua_field;

  assign frac_field = wr_data[FRAC_LSB +: FRAC_W];
  assign ir_field   = wr_data[IR_CNT_W-1:0];
  assign ua_field   = wr_data[UA_CNT_W-1:0];

  always_comb begin
    ir_frac_n = ir_frac_q;
    ir_cnt_n  = ir_cnt_q;
    ua_frac_n = ua_frac_q;
    ua_cnt_n  = ua_cnt_q;
    ir_rs_n   = 1'b0;
    ua_rs_n   = 1'b0;
    if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_IR_FRAC: ir_frac_n = frac_field;
        REG_IR_CNT: begin
          if (ir_field != '0) begin
            ir_cnt_n = ir_field;
            ir_rs_n  = 1'b1;
          end
        end
        REG_UA_FRAC: ua_frac_n = frac_field;
        REG_UA_CNT: begin
          ua_cnt_n = ua_field;
          ua_rs_n  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_frac_q <= '0;
      ir_cnt_q  <= IR_CNT_W'(IR_CNT_RST);
      ua_frac_q <= '0;
      ua_cnt_q  <= '0;
      ir_rs_q   <= 1'b1;
      ua_rs_q   <= 1'b1;
    end else begin
      if (wr_en) begin
        ir_frac_q <= ir_frac_n;
        ir_cnt_q  <= ir_cnt_n;
        ua_frac_q <= ua_frac_n;
        ua_cnt_q  <= ua_cnt_n;
      end
      ir_rs_q <= ir_rs_n;
      ua_rs_q <= ua_rs_n;
    end
  end

  assign ir_frac    = ir_frac_q;
  assign ir_cnt     = ir_cnt_q;
  assign ir_restart = ir_rs_q;
  assign ua_frac    = ua_frac_q;
  assign ua_cnt     = ua_cnt_q;
  assign ua_restart = ua_rs_q;
endmodule

// File: rtl/frac_baud_chan.sv
module frac_baud_chan
  import frac_baud_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PW-1:0]     int_period,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);
  logic [PW-1:0]     cnt_q, cnt_n;
  logic [FRAC_W-1:0] acc_q, acc_n;
  logic [FRAC_W:0]   acc_sum;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac};

  always_comb begin
    cnt_n = cnt_q - PW'(1);
    acc_n = acc_q;
    if (restart) begin
      cnt_n = int_period - PW'(1);
      acc_n = frac;
    end else if (at_zero) begin
      cnt_n = int_period - PW'(1) + PW'(acc_sum[FRAC_W]);
      acc_n = acc_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      acc_q <= acc_n;
    end
  end

  assign tick = at_zero && !restart;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int IR_CNT_W    = 4,
  parameter int UA_CNT_W    = 12,
  parameter int IR_CNT_RST  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        ir_tick,
  output logic        uart_tick
);
  localparam int IR_PW = IR_CNT_W + 1;
  localparam int UA_PW = UA_CNT_W + 5;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_sync;
  logic [FRAC_W-1:0]      ir_frac, ua_frac;
  logic [IR_CNT_W-1:0]    ir_cnt;
  logic [UA_CNT_W-1:0]    ua_cnt;
  logic                   ir_restart, ua_restart;
  logic [IR_PW-1:0]       ir_period;
  logic [UA_PW-1:0]       ua_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync = rs_q[SYNC_STAGES-1];

  frac_baud_regs #(
    .IR_CNT_W(IR_CNT_W), .UA_CNT_W(UA_CNT_W), .IR_CNT_RST(IR_CNT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ir_frac(ir_frac), .ir_cnt(ir_cnt),
    .ir_restart(ir_restart), .ua_frac(ua_frac), .ua_cnt(ua_cnt),
    .ua_restart(ua_restart)
  );

  assign ir_period = IR_PW'(ir_cnt) + IR_PW'(1);
  assign ua_period = (UA_PW'(ua_cnt) + UA_PW'(1)) << 4;

  frac_baud_chan #(.PW(IR_PW)) u_ir_chan (
    .clk(clk), .rst_n(rst_sync), .restart(ir_restart),
    .int_period(ir_period), .frac(ir_frac), .tick(ir_tick)
  );

  frac_baud_chan #(.PW(UA_PW)) u_ua_chan (
    .clk(clk), .rst_n(rst_sync), .restart(ua_restart),
    .int_period(ua_period), .frac(ua_frac), .tick(uart_tick)
  );
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk
  import frac_baud_pkg::*;
#(
  parameter int IR_CNT_W = 4,
  parameter int IR_PW    = 5,
  parameter int UA_PW    = 17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic [15:0]         wr_data,
  input logic [IR_CNT_W-1:0] ir_cnt,
  input logic                ir_restart,
  input logic                ua_restart,
  input logic [IR_PW-1:0]    ir_period,
  input logic [UA_PW-1:0]    ua_period,
  input logic                ir_tick,
  input logic                uart_tick
);
  logic [IR_PW:0] ir_since, ir_gap, ir_lo, ir_hi;
  logic [UA_PW:0] ua_since, ua_gap, ua_lo, ua_hi;
  logic           ir_zero_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_since <= '0;
      ua_since <= '0;
    end else begin
      ir_since <= (ir_restart || ir_tick) ? '0 : ir_since + (IR_PW+1)'(1);
      ua_since <= (ua_restart || uart_tick) ? '0 : ua_since + (UA_PW+1)'(1);
    end
  end

  assign ir_gap = ir_since + (IR_PW+1)'(1);
  assign ir_lo  = {1'b0, ir_period};
  assign ir_hi  = ir_lo + (IR_PW+1)'(1);
  assign ua_gap = ua_since + (UA_PW+1)'(1);
  assign ua_lo  = {1'b0, ua_period};
  assign ua_hi  = ua_lo + (UA_PW+1)'(1);
  assign ir_zero_wr = wr_en && (wr_addr == REG_IR_CNT) && (wr_data[IR_CNT_W-1:0] == '0);

  AST_IR_GAP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    ir_tick |-> (ir_gap == ir_lo || ir_gap == ir_hi)); // R6
  AST_UA_GAP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tick |-> (ua_gap == ua_lo || ua_gap == ua_hi)); // R6
  AST_IR_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ir_zero_wr |=> ($stable(ir_cnt) && !ir_restart)); // R4
  AST_NO_TICK_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_restart || ua_restart) |-> !((ir_restart && ir_tick) || (ua_restart && uart_tick))); // R7
  AST_IR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_tick |=> !ir_tick); // R8
  AST_UA_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tick |=> !uart_tick); // R8
endmodule

bind frac_baud_gen frac_baud_chk #(
  .IR_CNT_W(IR_CNT_W), .IR_PW(IR_PW), .UA_PW(UA_PW)
) u_chk (
  .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ir_cnt(ir_cnt), .ir_restart(ir_restart),
  .ua_restart(ua_restart), .ir_period(ir_period), .ua_period(ua_period),
  .ir_tick(ir_tick), .uart_tick(uart_tick)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ir_tick, uart_tick;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int    gap_q0[$], gap_q1[$], win_q0[$], win_q1[$];
  string tag0 = "R3", tag1 = "R5";
  int    cyc[2], wsum[2], wcnt[2], gidx[2];
  bit    prev_tk[2];

  always #4 clk = ~clk;

  frac_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ir_tick(ir_tick), .uart_tick(uart_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stretch(input int j, input int k);
    return ((j + 1) * k) / 16 - (j * k) / 16;
  endfunction

  // monitor: measures tick spacing and compares with queued expectations
  always @(negedge clk) begin
    if (!rst_n) begin
      check(ir_tick == 1'b0 && uart_tick == 1'b0, "R1", int'(ir_tick | uart_tick), 0);
      for (int ch = 0; ch < 2; ch++) begin
        cyc[ch] = 0; wsum[ch] = 0; wcnt[ch] = 0; gidx[ch] = 0; prev_tk[ch] = 1'b0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        bit tk;
        int e;
        string tg;
        tk = (ch == 0) ? ir_tick : uart_tick;
        cyc[ch]++;
        if (tk) begin
          check(!prev_tk[ch], "R8", int'(prev_tk[ch]), 0);
          if ((ch == 0 && gap_q0.size() > 0) || (ch == 1 && gap_q1.size() > 0)) begin
            e  = (ch == 0) ? gap_q0.pop_front() : gap_q1.pop_front();
            tg = (gidx[ch] == 0) ? "R7" : ((ch == 0) ? tag0 : tag1);
            check(cyc[ch] == e, tg, cyc[ch], e);
            gidx[ch]++;
            wsum[ch] += cyc[ch];
            wcnt[ch]++;
            if (wcnt[ch] == 16) begin
              if (ch == 0 && win_q0.size() > 0) begin
                e = win_q0.pop_front();
                check(wsum[ch] == e, "R6", wsum[ch], e);
              end else if (ch == 1 && win_q1.size() > 0) begin
                e = win_q1.pop_front();
                check(wsum[ch] == e, "R6", wsum[ch], e);
              end
              wsum[ch] = 0;
              wcnt[ch] = 0;
            end
          end
          cyc[ch] = 0;
        end
        prev_tk[ch] = tk;
      end
      // restart seen one half cycle before the accepting edge
      if (wr_en && wr_addr == 2'd1 && wr_data[3:0] != 4'd0) begin
        cyc[0] = -1; wsum[0] = 0; wcnt[0] = 0; gidx[0] = 0;
      end
      if (wr_en && wr_addr == 2'd3) begin
        cyc[1] = -1; wsum[1] = 0; wcnt[1] = 0; gidx[1] = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic push(input int ch, input int base, input int k, input int n);
    for (int j = 0; j < n; j++) begin
      if (ch == 0) gap_q0.push_back(base + stretch(j, k));
      else         gap_q1.push_back(base + stretch(j, k));
    end
    for (int w = 0; w < n / 16; w++) begin
      if (ch == 0) win_q0.push_back(16 * base + k);
      else         win_q1.push_back(16 * base + k);
    end
  endtask

  task automatic drain(input int ch);
    int left;
    left = 0;
    for (int t = 0; t < 20000; t++) begin
      left = (ch == 0) ? gap_q0.size() : gap_q1.size();
      if (left == 0) break;
      @(negedge clk);
    end
    check(left == 0, (ch == 0) ? tag0 : tag1, left, 0);
    gap_q0.delete(); gap_q1.delete(); win_q0.delete(); win_q1.delete();
  endtask

  // driver: IR run with fraction write data fd, count field cf
  task automatic run_ir(input string tg, input logic [15:0] fd, input int cf, input int n);
    tag0 = tg;
    wr(2'd0, fd);
    wr(2'd1, 16'(cf));
    push(0, cf + 1, int'(fd[7:4]), n);
    drain(0);
  endtask

  task automatic run_ua(input string tg, input logic [15:0] fd, input int cf, input int n);
    tag1 = tg;
    wr(2'd2, fd);
    wr(2'd3, 16'(cf));
    push(1, (cf + 1) * 16, int'(fd[7:4]), n);
    drain(1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: default infrared period of 2 after reset
    tag0 = "R1";
    @(negedge clk);
    while (!ir_tick) @(negedge clk);
    @(posedge clk);
    for (int j = 0; j < 4; j++) gap_q0.push_back(2);
    drain(0);

    run_ir("R3", 16'h0000, 3, 32);   // divisor 4, no fraction
    run_ir("R6", 16'h0050, 3, 32);   // divisor 4, index 5
    run_ir("R6", 16'h00F0, 15, 32);  // divisor 16, index 15
    run_ir("R3", 16'h0010, 1, 32);   // divisor 2, index 1
    run_ir("R2", 16'hAB5F, 2, 32);   // index 5 from bits 7:4, rest ignored

    // R4: zero count refused, cadence continues at divisor 4
    run_ir("R3", 16'h0000, 3, 16);
    tag0 = "R4";
    for (int j = 0; j < 16; j++) gap_q0.push_back(4);
    win_q0.push_back(64);
    wr(2'd1, 16'h0000);
    drain(0);

    run_ua("R5", 16'h0000, 0, 32);   // period 16
    run_ua("R6", 16'h0070, 2, 32);   // period 48, index 7
    run_ua("R2", 16'h3F9C, 0, 32);   // index 9, other bits ignored

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule